// File: doc/BRIEF.md
# Peripheral Register Space for an 8-bit Controller

This block is the register space that sits between a small 8-bit controller core and its peripherals. Each cycle the core presents one access: a short-form I/O read or write, a data-space load or store, a single-bit set or clear, or a single-bit test. The block maps all of these onto one register set. The set holds three general-purpose registers, an 8-bit status register whose flags are raised by hardware events and cleared by writing ones, and a 9-bit address register for a nonvolatile memory that is split across two bytes.

Short-form accesses use I/O addresses. Loads and stores use data addresses, which are the I/O address plus 0x20. Data addresses 0x60 and above form an extended region that only loads and stores can reach. Single-bit operations work on I/O addresses 0x00 to 0x1F only. A bit set or clear changes exactly one bit, so write-one-to-clear flags that share the register with the addressed bit are not disturbed. Read data and the skip condition appear in the cycle after the access.

Top module: `mcu_io_space`

## Requirements
- R1: Short-form I/O read (code 1) and write (code 2) reach the register at I/O address `addr` when `addr` is 0x3F or below. Above 0x3F the write is dropped and the read returns 0x00. Read data is registered and appears one cycle after the access. `rdata` is 0x00 after any access that is not a read.
- R2: A load (code 3) or store (code 4) at data address 0x20 to 0x5F reaches the same register as I/O address `addr`-0x20.
- R3: The nonvolatile-memory address register sits in the extended region, with its low byte at data address 0x61 and its high byte at 0x62. Only loads and stores reach it. Short-form accesses to 0x61 or 0x62 neither change it nor read it.
- R4: The status register is at I/O address 0x10. A byte write clears each flag whose written bit is 1 and leaves each flag whose written bit is 0.
- R5: Bit set (code 5) and bit clear (code 6) change only bit `bit_sel` of the addressed register. The general-purpose registers are at I/O addresses 0x11, 0x12 and 0x13. On the status register a bit set clears only the addressed flag, because it writes a one, and a bit clear has no effect.
- R6: Single-bit operations are accepted only for addresses 0x00 to 0x1F. Outside that range they change nothing and the test result is 0.
- R7: Test code 7 sets `skip` when the selected bit is 1. Test code 8 sets `skip` when the selected bit is 0. `skip` is valid one cycle after the test and is 0 after any other access.
- R8: The address register is 9 bits wide. Bit 0 of the high byte holds bit 8. Bits 7:1 of the high byte read as 0, and writes to them are discarded.
- R9: Writes to unmapped addresses have no effect, and reads of unmapped addresses return 0x00.
- R10: A one on bit i of `hw_event` sets status flag i at the next edge. This wins over a clear of the same flag in the same cycle.
- R11: After reset all registers, `rdata` and `skip` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_type | input | 4 | Access code: 0 idle, 1 I/O read, 2 I/O write, 3 load, 4 store, 5 bit set, 6 bit clear, 7 test skip-if-set, 8 test skip-if-clear |
| addr | input | 8 | I/O or data address, depending on the access code |
| wdata | input | 8 | Write data |
| bit_sel | input | 3 | Bit index for single-bit operations |
| hw_event | input | 8 | One-cycle flag-set pulses from peripherals |
| rdata | output | 8 | Registered read data |
| skip | output | 1 | Registered skip condition from a bit test |

## Verification
A wrong address map shows up on the very next cycle as wrong read data at an alias address or at an address that should be blocked. A read-modify-write in the single-bit path stays hidden until the status register is read back. At that point, flags that should have survived are missing. A wrong priority between event and clear loses a flag, and the loss is visible at the first status read after the collision. The reserved high-byte bits and the out-of-range rules are checked one cycle after the access that could break them.

// File: rtl/io_space_pkg.sv
package io_space_pkg;
  typedef enum logic [3:0] {
    ACC_IDLE  = 4'd0,
    ACC_IO_RD = 4'd1,
    ACC_IO_WR = 4'd2,
    ACC_LD    = 4'd3,
    ACC_ST    = 4'd4,
    ACC_BSET  = 4'd5,
    ACC_BCLR  = 4'd6,
    ACC_TSET  = 4'd7,
    ACC_TCLR  = 4'd8
  } acc_e;

  localparam int unsigned AW       = 8;
  localparam int unsigned IO_TOP   = 8'h3F;
  localparam int unsigned BIT_TOP  = 8'h1F;
  localparam int unsigned DS_OFS   = 8'h20;
  localparam int unsigned EXT_BASE = 8'h60;

  // Map an access onto an I/O index: {ok, index}.
  function automatic logic [AW:0] io_map(acc_e a, logic [AW-1:0] ad);
    logic [AW:0] r;
    r = '0;
    case (a)
      ACC_IO_RD, ACC_IO_WR:
        if (ad <= AW'(IO_TOP)) r = {1'b1, ad};
      ACC_LD, ACC_ST:
        if (ad >= AW'(DS_OFS) && ad < AW'(EXT_BASE)) r = {1'b1, ad - AW'(DS_OFS)};
      ACC_BSET, ACC_BCLR, ACC_TSET, ACC_TCLR:
        if (ad <= AW'(BIT_TOP)) r = {1'b1, ad};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] bit_mask(logic [2:0] b);
    return 8'(1) << b;
  endfunction
endpackage

// File: rtl/io_space_decode.sv
module io_space_decode
  import io_space_pkg::*;
#(
  parameter int unsigned NUM_GPR = 3,
  parameter logic [AW-1:0] STAT_A = 8'h10,
  parameter logic [AW-1:0] GPR_A  = 8'h11,
  parameter logic [AW-1:0] NVL_A  = 8'h61,
  parameter logic [AW-1:0] NVH_A  = 8'h62
) (
  input  acc_e               acc,
  input  logic [AW-1:0]      addr,
  output logic               is_rd,
  output logic               is_wr,
  output logic               is_bset,
  output logic               is_bclr,
  output logic               is_test,
  output logic               test_on_clear,
  output logic               io_ok,
  output logic               hit_stat,
  output logic [NUM_GPR-1:0] hit_gpr,
  output logic               hit_nvl,
  output logic               hit_nvh
);
  logic [AW:0]   mapped;
  logic [AW-1:0] io_idx;
  logic          ext_ok;

  always_comb begin
    mapped        = io_map(acc, addr);
    io_ok         = mapped[AW];
    io_idx        = mapped[AW-1:0];
    ext_ok        = (acc == ACC_LD || acc == ACC_ST) && (addr >= AW'(EXT_BASE));
    is_rd         = (acc == ACC_IO_RD) || (acc == ACC_LD);
    is_wr         = (acc == ACC_IO_WR) || (acc == ACC_ST);
    is_bset       = (acc == ACC_BSET) && io_ok;
    is_bclr       = (acc == ACC_BCLR) && io_ok;
    is_test       = (acc == ACC_TSET) || (acc == ACC_TCLR);
    test_on_clear = (acc == ACC_TCLR);
    hit_stat      = io_ok && (io_idx == STAT_A);
    hit_nvl       = ext_ok && (addr == NVL_A);
    hit_nvh       = ext_ok && (addr == NVH_A);
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_hit
    assign hit_gpr[g] = io_ok && (io_idx == GPR_A + AW'(g));
  end
endmodule

// File: rtl/io_status_reg.sv
module io_status_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] hw_set,
  input  logic          byte_wr,
  input  logic          bit_set_op,
  input  logic          bit_clr_op,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] flags_q
);
  logic [DW-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (byte_wr)         clr_vec = wdata;
    else if (bit_set_op) clr_vec = mask;   // a written one clears only that flag
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | hw_set;

  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(hw_set)) == $past(hw_set)));

  p_zero_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |=> ((flags_q & $past(flags_q & ~wdata)) == $past(flags_q & ~wdata)));

  p_bit_spares_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_set_op || bit_clr_op) |=>
      ((flags_q & $past(flags_q & ~mask)) == $past(flags_q & ~mask)));

  p_bclr_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_clr_op && !byte_wr && !bit_set_op) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/io_gpr_bank.sv
module io_gpr_bank #(
  parameter int unsigned DW      = 8,
  parameter int unsigned NUM_GPR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GPR-1:0] hit,
  input  logic               byte_wr,
  input  logic               bit_set_op,
  input  logic               bit_clr_op,
  input  logic [DW-1:0]      wdata,
  input  logic [DW-1:0]      mask,
  output logic [DW-1:0]      q [NUM_GPR]
);
  for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                   q[g] <= '0;
      else if (hit[g] && byte_wr)   q[g] <= wdata;
      else if (hit[g] && bit_set_op) q[g] <= q[g] | mask;
      else if (hit[g] && bit_clr_op) q[g] <= q[g] & ~mask;

    p_bit_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && (bit_set_op || bit_clr_op)) |=>
        ((q[g] & ~$past(mask)) == ($past(q[g]) & ~$past(mask))));
  end
endmodule

// File: rtl/io_nvm_addr.sv
module io_nvm_addr #(
  parameter int unsigned DW    = 8,
  parameter int unsigned NVA_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_lo,
  output logic [DW-1:0]    rd_hi
);
  localparam int unsigned HI_W = NVA_W - DW;
  logic [NVA_W-1:0] nva_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nva_q <= '0;
    else begin
      if (wr_lo) nva_q[DW-1:0]    <= wdata;
      if (wr_hi) nva_q[NVA_W-1:DW] <= wdata[HI_W-1:0];
    end

  assign rd_lo = nva_q[DW-1:0];
  assign rd_hi = {{(DW-HI_W){1'b0}}, nva_q[NVA_W-1:DW]};
endmodule

// File: rtl/mcu_io_space.sv
module mcu_io_space
  import io_space_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned NUM_GPR = 3,
  parameter int unsigned NVA_W   = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] acc_type,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic [2:0] bit_sel,
  input  logic [7:0] hw_event,
  output logic [7:0] rdata,
  output logic       skip
);
  acc_e               acc;
  logic               is_rd, is_wr, is_bset, is_bclr, is_test, test_on_clear, io_ok;
  logic               hit_stat, hit_nvl, hit_nvh, any_hit;
  logic [NUM_GPR-1:0] hit_gpr;
  logic [DW-1:0]      mask, flags, nv_lo, nv_hi, rd_val;
  logic [DW-1:0]      gpr_q [NUM_GPR];
  logic               sel_bit;

  assign acc  = acc_e'(acc_type);
  assign mask = bit_mask(bit_sel);

  io_space_decode #(.NUM_GPR(NUM_GPR)) u_dec (
    .acc(acc), .addr(addr), .is_rd(is_rd), .is_wr(is_wr), .is_bset(is_bset),
    .is_bclr(is_bclr), .is_test(is_test), .test_on_clear(test_on_clear),
    .io_ok(io_ok), .hit_stat(hit_stat), .hit_gpr(hit_gpr),
    .hit_nvl(hit_nvl), .hit_nvh(hit_nvh)
  );

  io_status_reg #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_event),
    .byte_wr(is_wr && hit_stat), .bit_set_op(is_bset && hit_stat),
    .bit_clr_op(is_bclr && hit_stat), .wdata(wdata), .mask(mask), .flags_q(flags)
  );

  io_gpr_bank #(.DW(DW), .NUM_GPR(NUM_GPR)) u_gpr (
    .clk(clk), .rst_n(rst_n), .hit(hit_gpr), .byte_wr(is_wr),
    .bit_set_op(is_bset), .bit_clr_op(is_bclr), .wdata(wdata), .mask(mask), .q(gpr_q)
  );

  io_nvm_addr #(.DW(DW), .NVA_W(NVA_W)) u_nva (
    .clk(clk), .rst_n(rst_n), .wr_lo(is_wr && hit_nvl), .wr_hi(is_wr && hit_nvh),
    .wdata(wdata), .rd_lo(nv_lo), .rd_hi(nv_hi)
  );

  always_comb begin
    rd_val = '0;
    if (hit_stat) rd_val = flags;
    for (int i = 0; i < int'(NUM_GPR); i++)
      if (hit_gpr[i]) rd_val = gpr_q[i];
    if (hit_nvl) rd_val = nv_lo;
    if (hit_nvh) rd_val = nv_hi;
    any_hit = hit_stat || (|hit_gpr) || hit_nvl || hit_nvh;
    sel_bit = rd_val[bit_sel];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata <= '0;
      skip  <= 1'b0;
    end else begin
      rdata <= is_rd ? rd_val : '0;
      skip  <= (is_test && io_ok) ? (sel_bit ^ test_on_clear) : 1'b0;
    end

  p_nvh_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && hit_nvh) |=> (rdata[7:1] == 7'd0));

  p_bit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_test && addr > 8'h1F) |=> !skip);

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !any_hit) |=> (rdata == 8'h00));

  p_skip_only_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_test |=> !skip);
endmodule

// File: tb/sim_mcu_io_space.sv
module sim_mcu_io_space;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] acc_type = 4'd0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, hw_event = 8'h00;
  logic [2:0] bit_sel = 3'd0;
  logic [7:0] rdata;
  logic       skip;
  int n_chk = 0, n_bad = 0;

  localparam logic [3:0] IDLE=0, IORD=1, IOWR=2, LD=3, ST=4, BSET=5, BCLR=6, TSET=7, TCLR=8;

  always #2 clk = ~clk;

  mcu_io_space u0 (.clk(clk), .rst_n(rst_n), .acc_type(acc_type), .addr(addr),
    .wdata(wdata), .bit_sel(bit_sel), .hw_event(hw_event), .rdata(rdata), .skip(skip));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One access; returns at the next falling edge, after the result is registered.
  task automatic op(logic [3:0] a, logic [7:0] ad, logic [7:0] wd = 8'h00,
                    logic [2:0] b = 3'd0, logic [7:0] ev = 8'h00);
    @(negedge clk);
    acc_type = a; addr = ad; wdata = wd; bit_sel = b; hw_event = ev;
    @(negedge clk);
    acc_type = IDLE; hw_event = 8'h00;
  endtask

  task automatic t_reset;
    chk("R11 rdata", rdata, 8'h00);
    chk("R11 skip", {7'd0, skip}, 8'h00);
    op(IORD, 8'h10); chk("R11 status", rdata, 8'h00);
    op(LD, 8'h62);   chk("R11 nvm hi", rdata, 8'h00);
  endtask

  task automatic t_io_rw;
    op(IOWR, 8'h11, 8'hA5); op(IORD, 8'h11); chk("R1 gpr0", rdata, 8'hA5);
    op(IDLE, 8'h11);        chk("R1 idle rdata", rdata, 8'h00);
    op(IORD, 8'h51);        chk("R1 above 3F", rdata, 8'h00);
  endtask

  task automatic t_alias;
    op(ST, 8'h32, 8'h3C); op(IORD, 8'h12); chk("R2 store->io", rdata, 8'h3C);
    op(IOWR, 8'h13, 8'h77); op(LD, 8'h33); chk("R2 io->load", rdata, 8'h77);
  endtask

  task automatic t_ext;
    op(ST, 8'h61, 8'h5A); op(LD, 8'h61); chk("R3 ext low", rdata, 8'h5A);
    op(IOWR, 8'h61, 8'hFF); op(LD, 8'h61); chk("R3 io write blocked", rdata, 8'h5A);
    op(IORD, 8'h61); chk("R3 io read blocked", rdata, 8'h00);
  endtask

  task automatic t_nvh;
    op(ST, 8'h62, 8'hFF); op(LD, 8'h62); chk("R8 hi reserved", rdata, 8'h01);
    op(LD, 8'h61); chk("R8 low intact", rdata, 8'h5A);
    op(ST, 8'h62, 8'hFE); op(LD, 8'h62); chk("R8 bit8 clear", rdata, 8'h00);
  endtask

  task automatic t_w1c;
    op(IDLE, 8'h00, 8'h00, 3'd0, 8'hF0); op(IORD, 8'h10); chk("R10 hw set", rdata, 8'hF0);
    op(IOWR, 8'h10, 8'h30); op(IORD, 8'h10); chk("R4 w1c", rdata, 8'hC0);
    op(IOWR, 8'h10, 8'h00); op(IORD, 8'h10); chk("R4 zeros keep", rdata, 8'hC0);
  endtask

  task automatic t_bitops;
    op(BSET, 8'h11, 8'h00, 3'd1); op(IORD, 8'h11); chk("R5 gpr bset", rdata, 8'hA7);
    op(BCLR, 8'h11, 8'h00, 3'd7); op(IORD, 8'h11); chk("R5 gpr bclr", rdata, 8'h27);
    op(BSET, 8'h10, 8'h00, 3'd6); op(IORD, 8'h10); chk("R5 status bset", rdata, 8'h80);
    op(BCLR, 8'h10, 8'h00, 3'd7); op(IORD, 8'h10); chk("R5 status bclr", rdata, 8'h80);
  endtask

  task automatic t_range;
    op(BSET, 8'h31, 8'h00, 3'd3); op(IORD, 8'h11); chk("R6 bset ignored", rdata, 8'h27);
    op(TSET, 8'h31, 8'h00, 3'd0); chk("R6 test out of range", {7'd0, skip}, 8'h00);
    op(TCLR, 8'h31, 8'h00, 3'd3); chk("R6 tclr out of range", {7'd0, skip}, 8'h00);
  endtask

  task automatic t_test;
    op(TSET, 8'h11, 8'h00, 3'd0); chk("R7 tset hit", {7'd0, skip}, 8'h01);
    op(TSET, 8'h11, 8'h00, 3'd3); chk("R7 tset miss", {7'd0, skip}, 8'h00);
    op(TCLR, 8'h11, 8'h00, 3'd3); chk("R7 tclr hit", {7'd0, skip}, 8'h01);
    op(TCLR, 8'h11, 8'h00, 3'd0); chk("R7 tclr miss", {7'd0, skip}, 8'h00);
    op(IDLE, 8'h11); chk("R7 skip drops", {7'd0, skip}, 8'h00);
  endtask

  task automatic t_unmapped;
    op(IOWR, 8'h05, 8'hFF); op(IORD, 8'h05); chk("R9 unmapped io", rdata, 8'h00);
    op(ST, 8'h70, 8'hFF); op(LD, 8'h70); chk("R9 unmapped ext", rdata, 8'h00);
  endtask

  task automatic t_hw_wins;
    op(IDLE, 8'h00, 8'h00, 3'd0, 8'h04);
    op(IOWR, 8'h10, 8'h04, 3'd0, 8'h04); op(IORD, 8'h10); chk("R10 set beats clear", rdata, 8'h84);
    op(BSET, 8'h10, 8'h00, 3'd2, 8'h04); op(IORD, 8'h10); chk("R10 set beats bset", rdata, 8'h84);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_io_rw; t_alias; t_ext; t_nvh; t_w1c;
    t_bitops; t_range; t_test; t_unmapped; t_hw_wins;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule